// File: doc/BRIEF.md
# Temporal Rule Checker

This block is an on-chip monitor for one fixed timing rule over four single-bit inputs. The rule is: `sigA` high, then `sigB` high on the next sampled edge, then `sigC` high on the edge after that, and `sigD` high two edges after the edge that sampled `sigC`. Every edge that samples `sigA` high starts a new attempt. Each attempt then moves through its own lifecycle: idle, watching (the first part of the trigger has been seen), armed (the whole trigger has been seen), and finally one of three outcomes. Those outcomes are hit (pass), void (vacuous pass) or miss (fail).

A pool of tracker slots holds the attempts, so overlapping attempts never interfere with each other. Five slots are enough for a new attempt on every cycle. A synchronous `disableIn` input ends every live attempt as a vacuous pass, and it blocks new attempts for as long as it is high. An `endOfTest` input turns attempts that are still waiting for `sigB` into vacuous passes. The block reports outcomes in two ways: a one-cycle pulse for each kind of outcome, and saturating counters that count every resolved attempt, including several that resolve on the same edge.

Top module: `temporal_rule_checker`

## Requirements
- R1: While `rstN` is low and on the first cycles after reset, all three pulses are low and all three counters read zero.
- R2: An attempt whose `sigB` is low on the edge after its `sigA` ends silently: it raises no pulse and changes no counter.
- R3: If `sigA`, `sigB`, `sigC` and `sigD` are sampled high on edges t, t+1, t+2 and t+4, and `disableIn` is low on those edges, `passPulse` is high for exactly the one cycle that follows edge t+4.
- R4: After a complete trigger, `sigC` sampled low on edge t+2 raises `failPulse` in the cycle after edge t+2. `sigD` sampled low on edge t+4, with `sigC` good, raises `failPulse` in the cycle after edge t+4.
- R5: `disableIn` sampled high turns every watching or armed attempt into a vacuous pass. `vacPulse` rises in the cycle after that edge, and a later `sigD` produces no pass. An edge that samples `sigA` together with `disableIn` starts no attempt.
- R6: `endOfTest` sampled high turns watching attempts into vacuous passes, and it wins over the `sigB` check on the same edge. Armed attempts ignore `endOfTest` and resolve normally.
- R7: An attempt may start on every edge. Overlapping attempts resolve independently, and none is dropped when the slot count is 5.
- R8: Each counter (`passCount`, `vacCount`, `failCount`) grows by the number of attempts with that outcome. The new value appears one edge after the pulse, so two attempts resolving on one edge add 2.
- R9: Counters saturate at all ones (65535 for 16 bits) and stay there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sigA | input | 1 | First trigger term; starts an attempt |
| sigB | input | 1 | Second trigger term, one edge after `sigA` |
| sigC | input | 1 | First result term, one edge after `sigB` |
| sigD | input | 1 | Second result term, two edges after `sigC` |
| disableIn | input | 1 | Aborts live attempts as vacuous passes; blocks starts |
| endOfTest | input | 1 | Ends watching attempts as vacuous passes |
| passPulse | output | 1 | High for one cycle when at least one attempt passes |
| vacPulse | output | 1 | High for one cycle when at least one attempt passes vacuously |
| failPulse | output | 1 | High for one cycle when at least one attempt fails |
| passCount | output | COUNT_W | Saturating count of real passes |
| vacCount | output | COUNT_W | Saturating count of vacuous passes |
| failCount | output | COUNT_W | Saturating count of failures |

## Verification
A pass pulse is due in the cycle after the edge that samples `sigD`, which is four edges after the edge that sampled `sigA`. A fail pulse is due after the edge that samples a bad `sigC` (two edges after `sigA`) or a bad `sigD` (four edges after `sigA`). A vacuous pulse is due after the edge that samples `disableIn` or `endOfTest`, and each counter moves one edge after its pulse. The driver stamps every expected item with the edge it is due after. The monitor compares items only in the half cycle that follows that edge, and it checks counters against totals built only from items due earlier.

// File: rtl/trc_pkg.sv
package trc_pkg;

  // Edges between the sigC check and the sigD check.
  localparam int C_TO_D  = 2;
  // Width of the per-cycle outcome tallies carried from control to datapath.
  localparam int TALLY_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,   // slot free
    ST_WATCH,  // sigA seen, waiting for sigB
    ST_ARMED,  // trigger complete, checking sigC / sigD
    ST_HIT,    // real pass, transient
    ST_VOID,   // vacuous pass, transient
    ST_MISS    // failure, transient
  } slotState_e;

  typedef struct packed {
    logic [TALLY_W-1:0] passN;
    logic [TALLY_W-1:0] vacN;
    logic [TALLY_W-1:0] failN;
  } tallyStrobe_t;

endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int SLOTS = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sigA,
  input  logic         sigB,
  input  logic         sigC,
  input  logic         sigD,
  input  logic         disableIn,
  input  logic         endOfTest,
  output tallyStrobe_t strobe
);

  localparam int PH_W = $clog2(C_TO_D + 1);

  logic [SLOTS-1:0] freeV;
  logic [SLOTS-1:0] grant;
  logic [SLOTS-1:0] hitV;
  logic [SLOTS-1:0] voidV;
  logic [SLOTS-1:0] missV;
  logic             startReq;

  assign startReq = sigA && !disableIn;

  // Lowest-index free slot takes the new attempt; terminal slots count as free.
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (startReq && freeV[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      slotState_e      curSt;
      slotState_e      nxtSt;
      logic [PH_W-1:0] curPh;
      logic [PH_W-1:0] nxtPh;

      always_comb begin
        nxtSt = curSt;
        nxtPh = curPh;
        unique case (curSt)
          ST_WATCH: begin
            if (disableIn || endOfTest) nxtSt = ST_VOID;
            else if (sigB) begin
              nxtSt = ST_ARMED;
              nxtPh = '0;
            end else nxtSt = ST_IDLE;
          end
          ST_ARMED: begin
            if (disableIn) nxtSt = ST_VOID;
            else if (curPh == '0) begin
              if (sigC) nxtPh = PH_W'(1);
              else      nxtSt = ST_MISS;
            end else if (curPh == PH_W'(C_TO_D)) begin
              nxtSt = sigD ? ST_HIT : ST_MISS;
            end else begin
              nxtPh = curPh + PH_W'(1);
            end
          end
          default: begin
            nxtSt = grant[i] ? ST_WATCH : ST_IDLE;
            nxtPh = '0;
          end
        endcase
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          curSt <= ST_IDLE;
          curPh <= '0;
        end else begin
          curSt <= nxtSt;
          curPh <= nxtPh;
        end
      end

      assign freeV[i] = (curSt != ST_WATCH) && (curSt != ST_ARMED);
      assign hitV[i]  = (curSt == ST_HIT);
      assign voidV[i] = (curSt == ST_VOID);
      assign missV[i] = (curSt == ST_MISS);
    end
  endgenerate

  always_comb begin
    strobe.passN = TALLY_W'($countones(hitV));
    strobe.vacN  = TALLY_W'($countones(voidV));
    strobe.failN = TALLY_W'($countones(missV));
  end

endmodule

// File: rtl/trc_satcnt.sv
module trc_satcnt #(
  parameter int COUNT_W = 16,
  parameter int INC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INC_W-1:0]   inc,
  output logic [COUNT_W-1:0] count
);

  localparam int SUM_W = COUNT_W + 1;

  logic [SUM_W-1:0] sum;
  assign sum = {1'b0, count} + SUM_W'(inc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (sum[COUNT_W]) count <= '1;
    else                   count <= sum[COUNT_W-1:0];
  end

endmodule

// File: rtl/trc_tally.sv
module trc_tally
  import trc_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  tallyStrobe_t       strobe,
  output logic               passPulse,
  output logic               vacPulse,
  output logic               failPulse,
  output logic [COUNT_W-1:0] passCount,
  output logic [COUNT_W-1:0] vacCount,
  output logic [COUNT_W-1:0] failCount
);

  assign passPulse = |strobe.passN;
  assign vacPulse  = |strobe.vacN;
  assign failPulse = |strobe.failN;

  trc_satcnt #(.COUNT_W(COUNT_W), .INC_W(TALLY_W)) passCtr (
    .clk(clk), .rstN(rstN), .inc(strobe.passN), .count(passCount)
  );
  trc_satcnt #(.COUNT_W(COUNT_W), .INC_W(TALLY_W)) vacCtr (
    .clk(clk), .rstN(rstN), .inc(strobe.vacN), .count(vacCount)
  );
  trc_satcnt #(.COUNT_W(COUNT_W), .INC_W(TALLY_W)) failCtr (
    .clk(clk), .rstN(rstN), .inc(strobe.failN), .count(failCount)
  );

endmodule

// File: rtl/temporal_rule_checker.sv
module temporal_rule_checker
  import trc_pkg::*;
#(
  parameter int SLOTS   = 5,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sigA,
  input  logic               sigB,
  input  logic               sigC,
  input  logic               sigD,
  input  logic               disableIn,
  input  logic               endOfTest,
  output logic               passPulse,
  output logic               vacPulse,
  output logic               failPulse,
  output logic [COUNT_W-1:0] passCount,
  output logic [COUNT_W-1:0] vacCount,
  output logic [COUNT_W-1:0] failCount
);

  tallyStrobe_t strobe;

  trc_ctrl #(.SLOTS(SLOTS)) ctrl (
    .clk(clk), .rstN(rstN),
    .sigA(sigA), .sigB(sigB), .sigC(sigC), .sigD(sigD),
    .disableIn(disableIn), .endOfTest(endOfTest),
    .strobe(strobe)
  );

  trc_tally #(.COUNT_W(COUNT_W)) tally (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .passPulse(passPulse), .vacPulse(vacPulse), .failPulse(failPulse),
    .passCount(passCount), .vacCount(vacCount), .failCount(failCount)
  );

endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               sigA,
  input logic               sigB,
  input logic               sigC,
  input logic               sigD,
  input logic               disableIn,
  input logic               endOfTest,
  input logic               passPulse,
  input logic               vacPulse,
  input logic               failPulse,
  input logic [COUNT_W-1:0] passCount,
  input logic [COUNT_W-1:0] vacCount,
  input logic [COUNT_W-1:0] failCount
);

  // R3: a pass implies the full rule was sampled with no disable on its last edge
  a_r3_pass_history: assert property (@(posedge clk) disable iff (!rstN)
    passPulse |-> ($past(sigD) && $past(sigC, 3) && $past(sigB, 4) &&
                   $past(sigA, 5) && !$past(disableIn)));

  // R4: a failure follows a low sigC or a low sigD on the previous edge
  a_r4_fail_cause: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |-> (!$past(sigC) || !$past(sigD)));

  // R5 / R6: a vacuous pass follows disable or end-of-test
  a_r5_vac_cause: assert property (@(posedge clk) disable iff (!rstN)
    vacPulse |-> ($past(disableIn) || $past(endOfTest)));

  // R5: two disabled edges in a row leave nothing to resolve
  a_r5_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    ($past(disableIn) && $past(disableIn, 2)) |-> !(passPulse || vacPulse || failPulse));

  // R8: a pass moves the pass counter unless it is saturated
  a_r8_pass_count_moves: assert property (@(posedge clk) disable iff (!rstN)
    (passPulse && (passCount != '1)) |=> (passCount > $past(passCount)));

  // R8: the fail counter only moves after a fail pulse
  a_r8_fail_count_steady: assert property (@(posedge clk) disable iff (!rstN)
    !failPulse |=> $stable(failCount));

  // R9: a saturated counter stays saturated
  a_r9_vac_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (vacCount == '1) |=> (vacCount == '1));

endmodule

bind temporal_rule_checker trc_checker #(.COUNT_W(COUNT_W)) chk (
  .clk(clk), .rstN(rstN),
  .sigA(sigA), .sigB(sigB), .sigC(sigC), .sigD(sigD),
  .disableIn(disableIn), .endOfTest(endOfTest),
  .passPulse(passPulse), .vacPulse(vacPulse), .failPulse(failPulse),
  .passCount(passCount), .vacCount(vacCount), .failCount(failCount)
);

// File: tb/tb_temporal_rule_checker.sv
`timescale 1ns/1ps
module tb_temporal_rule_checker;

  localparam int COUNT_W = 16;
  localparam int SAT     = (1 << COUNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sigA = 1'b0, sigB = 1'b0, sigC = 1'b0, sigD = 1'b0;
  logic disableIn = 1'b0, endOfTest = 1'b0;
  logic passPulse, vacPulse, failPulse;
  logic [COUNT_W-1:0] passCount, vacCount, failCount;

  always #5 clk = ~clk;

  temporal_rule_checker #(.SLOTS(5), .COUNT_W(COUNT_W)) dut (
    .clk(clk), .rstN(rstN),
    .sigA(sigA), .sigB(sigB), .sigC(sigC), .sigD(sigD),
    .disableIn(disableIn), .endOfTest(endOfTest),
    .passPulse(passPulse), .vacPulse(vacPulse), .failPulse(failPulse),
    .passCount(passCount), .vacCount(vacCount), .failCount(failCount)
  );

  typedef struct {
    int    due;
    int    nP;
    int    nV;
    int    nF;
    bit    cnt;
    string tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  int    runP = 0, runV = 0, runF = 0;
  bit    finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int sat(input int v);
    return (v > SAT) ? SAT : v;
  endfunction

  // Monitor: pops items due after the edge just passed.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      check(passPulse == (it.nP > 0), it.tag, "passPulse", int'(passPulse), int'(it.nP > 0));
      check(vacPulse  == (it.nV > 0), it.tag, "vacPulse",  int'(vacPulse),  int'(it.nV > 0));
      check(failPulse == (it.nF > 0), it.tag, "failPulse", int'(failPulse), int'(it.nF > 0));
      if (it.cnt) begin
        check(int'(passCount) == runP, it.tag, "passCount", int'(passCount), runP);
        check(int'(vacCount)  == runV, it.tag, "vacCount",  int'(vacCount),  runV);
        check(int'(failCount) == runF, it.tag, "failCount", int'(failCount), runF);
      end
      runP = sat(runP + it.nP);
      runV = sat(runV + it.nV);
      runF = sat(runF + it.nF);
    end
  end

  // Driver: sets inputs for the next edge and queues what is due after it.
  task automatic step(input logic a, b, c, d, dis, eot,
                      input int nP, nV, nF, input bit cnt, input string tag);
    item_t it;
    @(posedge clk); #1;
    sigA = a; sigB = b; sigC = c; sigD = d; disableIn = dis; endOfTest = eot;
    it.due = cyc + 1; it.nP = nP; it.nV = nV; it.nF = nF; it.cnt = cnt; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input bit cnt, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, cnt, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    check(!passPulse && !vacPulse && !failPulse, "R1", "pulses in reset",
          int'({passPulse, vacPulse, failPulse}), 0);
    check(passCount == 0 && vacCount == 0 && failCount == 0, "R1", "counters in reset",
          int'(passCount) + int'(vacCount) + int'(failCount), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    idle(2, 1, "R1");

    // R2: sigB low after sigA ends silently
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    idle(4, 1, "R2");

    // R3: full match passes after the sigD edge, for one cycle
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 0, 0, 1, 0, 0, 0, "R3");
    idle(1, 1, "R8");

    // R4: sigC low fails two edges after sigA
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R4");
    idle(2, 0, "R4");
    // R4: sigD low fails four edges after sigA
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R4");
    idle(1, 1, "R4");

    // R5: disable aborts an armed attempt; the later sigD gives no pass
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 1, 0, 0, 1, 0, 0, "R5");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R5");
    idle(1, 0, "R5");
    // R5: disable aborts a watching attempt
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 0, 1, 0, 0, 1, 0, 0, "R5");
    idle(1, 0, "R5");
    // R5: sigA under disable starts nothing
    step(1, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R5");
    idle(1, 1, "R5");

    // R6: end-of-test beats the sigB check of a watching attempt
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 1, 0, 1, 0, 0, "R6");
    idle(1, 0, "R6");
    // R6: an armed attempt ignores end-of-test and still passes
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 1, 0, 0, 1, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 0, 0, 1, 0, 0, 0, "R6");
    idle(1, 1, "R6");

    // R7: an attempt on every edge; four passes, then two fails on one edge
    for (int i = 0; i < 8; i++)
      step(1, 1, 1, 1, 0, 0, (i >= 4) ? 1 : 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, 2, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7");
    idle(2, 1, "R8");

    // R8: three live attempts aborted on one edge add three
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 0, 0, 3, 0, 0, "R8");
    idle(2, 1, "R8");

    // R9: one vacuous pass per edge until the counter saturates
    for (int i = 0; i < 65600; i++) begin
      @(posedge clk); #1;
      sigA = 1'b1; sigB = 1'b0; sigC = 1'b0; sigD = 1'b0;
      disableIn = 1'b0; endOfTest = 1'b1;
    end
    runV = SAT;
    step(0, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R9");
    idle(3, 1, "R9");

    @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule